// File: doc/BRIEF.md
# ATM Cell Receiver for the PHY Side of a Multi-PHY Byte Bus

This block sits at the PHY end of a byte-wide, cell-level, multi-PHY ATM transfer bus. An ATM-layer master sends 53-byte cells to it on an 8-bit data bus. The master marks the first byte of each cell with a start-of-cell strobe and qualifies every valid byte with an active-low enable. Framing depends only on the start-of-cell strobe. Any byte that is not part of a cell is thrown away. A start-of-cell that arrives partway through a cell discards the partial cell and starts a new one.

The master polls PHY devices by putting a 5-bit address on a shared poll bus. When that address equals the block's configured address, the block drives its cell-available flag in the following cycle. The flag is high when the block has room for a whole cell. The flag is tri-stateable. Its enable is a separate output, so the bus driver is built outside the block.

Accepted cells go into a two-slot internal buffer. Downstream logic drains each stored cell as a valid/ready byte stream with start and end markers. The block holds `out_valid` while any stored cell remains unread. `out_data`, `out_sof` and `out_eof` stay frozen while `out_ready` is low, and there is no timeout. A slot becomes free on the edge that accepts the last byte of its cell. A one-cycle `cell_done` pulse reports each newly stored cell.

Top module: `utopia_phy_rx`

## Requirements
- R1: A cell is 53 bytes: the byte taken with `tx_soc` high (byte 0) and then 52 more taken bytes. `cell_done` is high for exactly one cycle, the cycle after the edge that takes byte 52. The stored bytes later leave the block in the order they arrived.
- R2: A byte is taken only on a rising edge where `tx_enb_n` is 0. Edges with `tx_enb_n` at 1 neither store a byte nor advance the byte count.
- R3: A byte taken while no cell is open and `tx_soc` is 0 is ignored. This covers bytes after byte 52 and bytes before the next start. A `tx_soc` of 1 on an edge with `tx_enb_n` at 1 starts nothing.
- R4: A taken byte with `tx_soc` high during an open cell discards the partial cell. That byte becomes byte 0 of a new cell in the same slot.
- R5: `clav_oe` is 1 in exactly those cycles that follow a rising edge on which the 5-bit `poll_addr` (bit 4 most significant) equalled `my_addr`. It is 0 in all other cycles.
- R6: In a cycle where `clav_oe` is 1, `clav_o` is 1 if and only if, at the polling edge, the stored-cell count plus one for an open cell was below 2. `clav_o` is 0 whenever `clav_oe` is 0.
- R7: The buffer holds at most 2 cells. A start-of-cell that arrives while 2 cells are stored and no cell is open is ignored, together with the whole cell it begins. No `cell_done` is raised for it.
- R8: `out_valid` is 1 while at least one stored cell is unread. A byte moves on each edge where `out_valid` and `out_ready` are both 1. `out_sof` marks byte 0 and `out_eof` marks byte 52. While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady. Moving byte 52 frees the slot, and the next poll can then report room.
- R9: While `rst_n` is low, and after it is released, `clav_oe`, `clav_o`, `out_valid` and `cell_done` are 0 until a poll or a cell changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | 5 | This block's poll address (configuration) |
| poll_addr | input | 5 | Poll/select address driven by the master |
| tx_data | input | 8 | Cell byte from the master, bit 7 most significant |
| tx_soc | input | 1 | High with byte 0 of a cell |
| tx_enb_n | input | 1 | Active-low byte enable |
| clav_o | output | 1 | Cell-available value for the tri-state driver |
| clav_oe | output | 1 | Output enable of the cell-available driver |
| cell_done | output | 1 | One-cycle pulse when a full cell is stored |
| out_valid | output | 1 | Stored byte present on `out_data` |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Stored cell byte |
| out_sof | output | 1 | `out_data` is byte 0 of a cell |
| out_eof | output | 1 | `out_data` is byte 52 of a cell |

## Verification
The bound checker tests the following on every cycle: the poll-to-enable timing, that the flag is never driven high without its enable, the upper limit on stored cells, that the flag stays low while the buffer is full, that `cell_done` lasts one cycle, and that the output stream holds under back-pressure. Other behaviour shows up only in the bench's cell scenarios. This includes the exact 53-byte framing across enable gaps, the dropping of stray bytes and of strobes without enable, the restart after a mid-cell strobe, the loss of a whole cell offered to a full buffer, the flag reporting no room while a second cell is being written, and the byte order of the stored cells.

// File: rtl/upr_pkg.sv
package upr_pkg;
  localparam int CELL_BYTES = 53;
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int ADDR_W     = 5;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/upr_poll.sv
module upr_poll
  import upr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic              room,
  output logic              clav_o,
  output logic              clav_oe
);
  logic hit;
  assign hit = (poll_addr == my_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clav_oe <= 1'b0;
      clav_o  <= 1'b0;
    end else begin
      clav_oe <= hit;
      clav_o  <= hit & room;
    end
  end
endmodule

// File: rtl/upr_framer.sv
module upr_framer
  import upr_pkg::*;
#(
  parameter int NCELL = 2,
  localparam int SW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  byte_t            tx_data,
  input  logic             tx_soc,
  input  logic             tx_enb_n,
  input  logic             may_start,
  output logic             wr_en,
  output logic [SW-1:0]    wr_slot,
  output logic [IDX_W-1:0] wr_idx,
  output byte_t            wr_data,
  output logic             wr_last,
  output logic             in_cell,
  output logic             cell_done
);
  logic [IDX_W-1:0] cnt;
  logic             take, start, cont, at_end;

  assign take    = ~tx_enb_n;
  assign start   = take & tx_soc & (in_cell | may_start);
  assign cont    = take & ~tx_soc & in_cell;
  assign at_end  = (cnt == IDX_W'(CELL_BYTES - 1));
  assign wr_en   = start | cont;
  assign wr_idx  = start ? '0 : cnt;
  assign wr_data = tx_data;
  assign wr_last = cont & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cell   <= 1'b0;
      cnt       <= '0;
      wr_slot   <= '0;
      cell_done <= 1'b0;
    end else begin
      cell_done <= wr_last;
      if (start) begin
        in_cell <= 1'b1;
        cnt     <= IDX_W'(1);
      end else if (cont) begin
        if (at_end) begin
          in_cell <= 1'b0;
          cnt     <= '0;
          wr_slot <= (wr_slot == SW'(NCELL - 1)) ? '0 : wr_slot + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/upr_cellbuf.sv
module upr_cellbuf
  import upr_pkg::*;
#(
  parameter int NCELL = 2,
  localparam int SW    = (NCELL > 1) ? $clog2(NCELL) : 1,
  localparam int CW    = $clog2(NCELL + 1),
  localparam int DEPTH = NCELL * CELL_BYTES,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_slot,
  input  logic [IDX_W-1:0] wr_idx,
  input  byte_t            wr_data,
  input  logic             wr_last,
  output logic [CW-1:0]    stored_cnt,
  output logic             out_valid,
  input  logic             out_ready,
  output byte_t            out_data,
  output logic             out_sof,
  output logic             out_eof
);
  byte_t            mem [DEPTH];
  logic [SW-1:0]    rslot;
  logic [IDX_W-1:0] ridx;
  logic             xfer, pop;

  function automatic logic [AW-1:0] loc(logic [SW-1:0] s, logic [IDX_W-1:0] i);
    return AW'(s) * AW'(CELL_BYTES) + AW'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[loc(wr_slot, wr_idx)] <= wr_data;
  end

  assign out_valid = (stored_cnt != '0);
  assign out_data  = mem[loc(rslot, ridx)];
  assign out_sof   = (ridx == '0);
  assign out_eof   = (ridx == IDX_W'(CELL_BYTES - 1));
  assign xfer      = out_valid & out_ready;
  assign pop       = xfer & out_eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_cnt <= '0;
      rslot      <= '0;
      ridx       <= '0;
    end else begin
      stored_cnt <= stored_cnt + CW'(wr_last) - CW'(pop);
      if (xfer) begin
        if (out_eof) begin
          ridx  <= '0;
          rslot <= (rslot == SW'(NCELL - 1)) ? '0 : rslot + 1'b1;
        end else begin
          ridx <= ridx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/utopia_phy_rx.sv
module utopia_phy_rx
  import upr_pkg::*;
#(
  parameter int NCELL = 2,
  localparam int SW = (NCELL > 1) ? $clog2(NCELL) : 1,
  localparam int CW = $clog2(NCELL + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] my_addr,
  input  logic [4:0] poll_addr,
  input  logic [7:0] tx_data,
  input  logic       tx_soc,
  input  logic       tx_enb_n,
  output logic       clav_o,
  output logic       clav_oe,
  output logic       cell_done,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  logic             wr_en, wr_last, in_cell, may_start, room;
  logic [SW-1:0]    wr_slot;
  logic [IDX_W-1:0] wr_idx;
  byte_t            wr_data;
  logic [CW-1:0]    stored_cnt;
  logic [CW:0]      occ;

  assign occ       = {1'b0, stored_cnt} + (CW+1)'(in_cell);
  assign room      = (occ < (CW+1)'(NCELL));
  assign may_start = (stored_cnt < CW'(NCELL));

  upr_poll u_poll (
    .clk, .rst_n, .my_addr, .poll_addr, .room, .clav_o, .clav_oe
  );

  upr_framer #(.NCELL(NCELL)) u_framer (
    .clk, .rst_n, .tx_data, .tx_soc, .tx_enb_n, .may_start,
    .wr_en, .wr_slot, .wr_idx, .wr_data, .wr_last, .in_cell, .cell_done
  );

  upr_cellbuf #(.NCELL(NCELL)) u_buf (
    .clk, .rst_n, .wr_en, .wr_slot, .wr_idx, .wr_data, .wr_last,
    .stored_cnt, .out_valid, .out_ready, .out_data, .out_sof, .out_eof
  );
endmodule

// File: rtl/upr_checks.sv
module upr_checks #(
  parameter int NCELL = 2,
  localparam int CW = $clog2(NCELL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    my_addr,
  input logic [4:0]    poll_addr,
  input logic          clav_o,
  input logic          clav_oe,
  input logic          cell_done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_sof,
  input logic          out_eof,
  input logic [CW-1:0] stored_cnt
);
  a_r5_oe_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_addr == my_addr) |=> clav_oe);

  a_r5_oe_only_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_addr != my_addr) |=> !clav_oe);

  a_r6_clav_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    clav_o |-> clav_oe);

  a_r6_full_no_clav: assert property (@(posedge clk) disable iff (!rst_n)
    (stored_cnt == CW'(NCELL)) |=> !clav_o);

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stored_cnt <= CW'(NCELL));

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cell_done |=> !cell_done);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));
endmodule

bind utopia_phy_rx upr_checks #(.NCELL(NCELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .poll_addr(poll_addr),
  .clav_o(clav_o), .clav_oe(clav_oe), .cell_done(cell_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof), .stored_cnt(stored_cnt)
);

// File: tb/tb_utopia_phy_rx.sv
`timescale 1ns/1ps
module tb_utopia_phy_rx;
  localparam logic [4:0] MINE = 5'h0B;
  localparam logic [4:0] IDLE = 5'h1E;
  // {poll address, expected enable, expected flag} with an empty buffer
  localparam logic [6:0] POLL_TAB [8] = '{
    {5'h0B, 1'b1, 1'b1}, {5'h0A, 1'b0, 1'b0}, {5'h1B, 1'b0, 1'b0},
    {5'h0F, 1'b0, 1'b0}, {5'h0B, 1'b1, 1'b1}, {5'h1F, 1'b0, 1'b0},
    {5'h03, 1'b0, 1'b0}, {5'h09, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [4:0] poll_addr = IDLE;
  logic [7:0] tx_data = 0;
  logic tx_soc = 0, tx_enb_n = 1, out_ready = 0;
  logic clav_o, clav_oe, cell_done, out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  utopia_phy_rx dut (
    .clk, .rst_n, .my_addr(MINE), .poll_addr, .tx_data, .tx_soc, .tx_enb_n,
    .clav_o, .clav_oe, .cell_done, .out_valid, .out_ready, .out_data,
    .out_sof, .out_eof
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic poll(input logic [4:0] a, input bit e_oe, input bit e_cl,
                      input string req);
    @(negedge clk) poll_addr = a;
    @(negedge clk);
    chk(clav_oe == e_oe, req, "clav_oe after poll", clav_oe, e_oe);
    chk(clav_o == e_cl, req, "clav_o after poll", clav_o, e_cl);
    poll_addr = IDLE;
    @(negedge clk);
    chk(!clav_oe && !clav_o, "R5", "enable drops after poll", clav_oe, 0);
  endtask

  // bytes first..last of a cell, value seed+i; optional enable gaps
  task automatic send(input int seed, input int first, input int last,
                      input bit gaps);
    for (int i = first; i <= last; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk) tx_enb_n = 1; tx_soc = 0; tx_data = 8'hEE;
      end
      @(negedge clk) tx_enb_n = 0; tx_soc = (i == 0); tx_data = 8'(seed + i);
    end
    @(negedge clk) tx_enb_n = 1; tx_soc = 0;
  endtask

  task automatic stray(input int n, input bit soc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tx_enb_n = soc; tx_soc = soc; tx_data = 8'hA5;
    end
    @(negedge clk) tx_enb_n = 1; tx_soc = 0;
  endtask

  task automatic read_cell(input int seed, input bit stall, input string req);
    int errs = 0;
    int first_bad = 0;
    @(negedge clk);
    for (int i = 0; i < 53; i++) begin
      if (!out_valid || out_data != 8'(seed + i) ||
          out_sof != (i == 0) || out_eof != (i == 52)) begin
        if (errs == 0) first_bad = out_data;
        errs++;
      end
      if (stall && i == 5) begin
        out_ready = 0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid && out_data == 8'(seed + 5) && !out_sof && !out_eof,
            "R8", "byte held under back-pressure", out_data, seed + 5);
      end
      out_ready = 1;
      @(negedge clk);
    end
    out_ready = 0;
    chk(errs == 0, req, "cell bytes in order", first_bad, seed);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!clav_oe && !clav_o && !out_valid && !cell_done, "R9", "state in reset",
        {clav_oe, clav_o, out_valid, cell_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!clav_oe && !out_valid && !cell_done, "R9", "state after reset",
        {clav_oe, out_valid, cell_done}, 0);

    // R5/R6 poll table
    foreach (POLL_TAB[k])
      poll(POLL_TAB[k][6:2], POLL_TAB[k][1], POLL_TAB[k][0], "R5");

    // R1 plain cell, with back-pressure on readout (R8)
    send(10, 0, 51, 0);
    chk(!out_valid, "R1", "no cell after 52 bytes", out_valid, 0);
    @(negedge clk) tx_enb_n = 0; tx_data = 8'(10 + 52);
    @(negedge clk) tx_enb_n = 1;
    chk(cell_done == 1, "R1", "cell_done after byte 52", cell_done, 1);
    @(negedge clk);
    chk(cell_done == 0, "R1", "cell_done one cycle", cell_done, 0);
    read_cell(10, 1, "R1");
    chk(!out_valid, "R8", "empty after read", out_valid, 0);

    // R2 gaps, R3 stray bytes and strobe without enable
    stray(3, 0);
    stray(1, 1);
    send(40, 0, 52, 1);
    stray(4, 0);
    chk(out_valid, "R2", "cell stored across gaps", out_valid, 1);
    read_cell(40, 0, "R2");
    chk(!out_valid, "R3", "stray bytes stored nothing", out_valid, 0);

    // R4 restart on mid-cell strobe
    send(70, 0, 19, 0);
    send(90, 0, 52, 0);
    read_cell(90, 0, "R4");
    chk(!out_valid, "R4", "partial cell discarded", out_valid, 0);

    // R6 no room while second cell is open, R7 full drops
    send(120, 0, 52, 0);
    poll(MINE, 1, 1, "R6");
    send(160, 0, 9, 0);
    poll(MINE, 1, 0, "R6");
    send(160, 10, 52, 0);
    poll(MINE, 1, 0, "R6");
    send(200, 0, 51, 0);
    @(negedge clk) tx_enb_n = 0; tx_data = 8'(200 + 52);
    @(negedge clk) tx_enb_n = 1;
    chk(cell_done == 0, "R7", "no cell_done when full", cell_done, 0);
    read_cell(120, 0, "R7");
    poll(MINE, 1, 1, "R8");
    read_cell(160, 0, "R7");
    chk(!out_valid, "R7", "third cell dropped", out_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule